// File: doc/BRIEF.md
# Flow-Control Status Calendar Receiver

This block sits behind the pins of a 2-bit-per-cycle flow-control status channel. It searches the incoming stream for a framing word (binary 11), treats the next word as the first calendar slot, and then steps through a programmable calendar. For each slot it gives the received status together with the logical port number read from a port table input. The calendar holds four times one more than its 6-bit length field, and it repeats one more time than its 8-bit repetition field. After the last repetition there is one parity word and then a framing word.

The parity word is checked so that the whole span, from the word after a framing word through the parity word itself, gives zero when all its words are XOR-ed together. The lock state follows these checks and the framing position. A saturating error counter counts parity mismatches. Two read-only registers make the lock state and the count visible, and reading the count clears it.

Top module: `sts_cal_rx`

## Requirements
- R1: While not aligned, no slot strobe is produced until an 11 word arrives. The word right after it is calendar slot 0.
- R2: The calendar has 4*(len_f_i+1) slots, visited in increasing order. Each slot word raises st_valid_o in the same cycle and gives st_port_o = the table entry at bits [slot*PORT_W +: PORT_W] of cal_tbl_i. No other word raises st_valid_o.
- R3: The calendar is walked m_f_i+1 times. Then exactly one parity word is expected, then one framing word (11), and then slot 0 again.
- R4: A parity check passes when the bitwise XOR of every 2-bit word from the word after a framing word through the parity word equals 00. Otherwise it fails.
- R5: The lock flag resets to 0. It becomes 1 after 4 consecutive passing parity checks.
- R6: While locked, fewer than 4 consecutive failing checks keep the lock, and any passing check restarts that run. The 4th consecutive failure drops the lock.
- R7: If a word other than 11 arrives where a framing word is due, the lock drops at once and the block goes back to searching (R1).
- R8: While unlocked, st_val_o is forced to 10 on every slot. While locked it carries the received word.
- R9: Every failing parity check adds one to an error counter of CNT_W bits (default 16), whether locked or not. The counter stops at 2^CNT_W-1 and resets to 0.
- R10: A read with rd_sel_i=1 returns the count on rd_data_o in that cycle and clears the counter at the next edge. A failing check in that same cycle leaves the counter at 1.
- R11: With rd_sel_i=0, rd_data_o bit 0 is the lock flag and the other bits are 0. With rd_sel_i=1 the count is given zero-extended.
- R12: cfg_err_o is 1 exactly when 4*(len_f_i+1) is less than act_ports_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Status channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_i | input | 2 | Received status word |
| len_f_i | input | LEN_W | Calendar length field |
| m_f_i | input | M_W | Repetition field |
| cal_tbl_i | input | (4<<LEN_W)*PORT_W | Port number per calendar slot |
| act_ports_i | input | LEN_W+3 | Number of active logical ports |
| st_valid_o | output | 1 | Slot status strobe |
| st_port_o | output | PORT_W | Port of the current slot |
| st_val_o | output | 2 | Status for that port |
| cfg_err_o | output | 1 | Calendar shorter than port count |
| rd_en_i | input | 1 | Register read strobe |
| rd_sel_i | input | 1 | 0: lock flag, 1: error count |
| rd_data_o | output | RD_W | Read data |

## Verification
The assertions check several things on every cycle. The counter moves only upward except on a clearing read, a read leaves at most 1, the counter holds at its ceiling, and a failing check adds exactly one when below it. The lock only rises after a passing check and always falls after a missed framing word. A parity slot is always followed by a framing slot. The remaining behaviour can only be shown by the bench's scenarios: the exact slot-to-port mapping across length and repetition settings, the cycle at which lock is gained or lost, the forced status while unlocked, and the read-and-error collision.

// File: rtl/sts_cal_pkg.sv
package sts_cal_pkg;
  typedef enum logic [1:0] {
    PH_HUNT = 2'd0,
    PH_CAL  = 2'd1,
    PH_DIP  = 2'd2,
    PH_FRM  = 2'd3
  } cal_phase_e;

  localparam logic [1:0] W_FRAME = 2'b11;
  localparam logic [1:0] W_IDLE  = 2'b10;
endpackage

// File: rtl/sts_cal_walker.sv
module sts_cal_walker
  import sts_cal_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int M_W   = 8,
  localparam int IDX_W = LEN_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       stat_i,
  input  logic [LEN_W-1:0] len_f_i,
  input  logic [M_W-1:0]   m_f_i,
  output cal_phase_e       phase_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             frame_miss_o
);
  cal_phase_e       ph_q, ph_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [M_W-1:0]   rep_q, rep_d;
  logic             last_slot;

  assign last_slot = (idx_q == {len_f_i, 2'b11});

  always_comb begin
    ph_d  = ph_q;
    idx_d = idx_q;
    rep_d = rep_q;
    case (ph_q)
      PH_HUNT: begin
        if (stat_i == W_FRAME) begin
          ph_d  = PH_CAL;
          idx_d = '0;
          rep_d = '0;
        end
      end
      PH_CAL: begin
        if (last_slot) begin
          idx_d = '0;
          if (rep_q == m_f_i) ph_d = PH_DIP;
          else rep_d = rep_q + 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      PH_DIP: ph_d = PH_FRM;
      PH_FRM: begin
        if (stat_i == W_FRAME) begin
          ph_d  = PH_CAL;
          idx_d = '0;
          rep_d = '0;
        end else begin
          ph_d = PH_HUNT;
        end
      end
      default: ph_d = PH_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_HUNT;
      idx_q <= '0;
      rep_q <= '0;
    end else begin
      ph_q  <= ph_d;
      idx_q <= idx_d;
      rep_q <= rep_d;
    end
  end

  assign phase_o      = ph_q;
  assign idx_o        = idx_q;
  assign frame_miss_o = (ph_q == PH_FRM) && (stat_i != W_FRAME);
endmodule

// File: rtl/sts_dip2_chk.sv
module sts_dip2_chk
  import sts_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] stat_i,
  input  cal_phase_e phase_i,
  output logic       good_o,
  output logic       bad_o
);
  logic [1:0] acc_q, acc_d;
  logic       acc_en;
  logic [1:0] sum;

  always_comb begin
    acc_en = 1'b0;
    acc_d  = acc_q;
    if ((phase_i == PH_HUNT || phase_i == PH_FRM) && stat_i == W_FRAME) begin
      acc_en = 1'b1;
      acc_d  = '0;
    end else if (phase_i == PH_CAL) begin
      acc_en = 1'b1;
      acc_d  = acc_q ^ stat_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign sum    = acc_q ^ stat_i;
  assign good_o = (phase_i == PH_DIP) && (sum == 2'b00);
  assign bad_o  = (phase_i == PH_DIP) && (sum != 2'b00);
endmodule

// File: rtl/sts_sync_trk.sv
module sts_sync_trk #(
  parameter int LOCK_N = 4,
  parameter int LOSE_N = 4,
  localparam int MAX_N = (LOCK_N > LOSE_N) ? LOCK_N : LOSE_N,
  localparam int CW    = $clog2(MAX_N) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_miss_i,
  input  logic good_i,
  input  logic bad_i,
  output logic sync_o
);
  logic          sync_q, sync_d;
  logic [CW-1:0] g_q, g_d, b_q, b_d;

  always_comb begin
    sync_d = sync_q;
    g_d    = g_q;
    b_d    = b_q;
    if (frame_miss_i) begin
      sync_d = 1'b0;
      g_d    = '0;
      b_d    = '0;
    end else if (good_i) begin
      b_d = '0;
      if (!sync_q) begin
        if (g_q == CW'(LOCK_N - 1)) begin
          sync_d = 1'b1;
          g_d    = '0;
        end else begin
          g_d = g_q + 1'b1;
        end
      end
    end else if (bad_i) begin
      g_d = '0;
      if (sync_q) begin
        if (b_q == CW'(LOSE_N - 1)) begin
          sync_d = 1'b0;
          b_d    = '0;
        end else begin
          b_d = b_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      g_q    <= '0;
      b_q    <= '0;
    end else begin
      sync_q <= sync_d;
      g_q    <= g_d;
      b_q    <= b_d;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/sts_err_cnt.sv
module sts_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_max;

  assign at_max = &cnt_q;

  always_comb begin
    cnt_en = clr_i || (inc_i && !at_max);
    if (clr_i) cnt_d = inc_i ? CNT_W'(1) : '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sts_cal_rx.sv
module sts_cal_rx
  import sts_cal_pkg::*;
#(
  parameter int LEN_W  = 6,
  parameter int M_W    = 8,
  parameter int PORT_W = 8,
  parameter int CNT_W  = 16,
  parameter int RD_W   = 16,
  parameter int LOCK_N = 4,
  parameter int LOSE_N = 4,
  localparam int IDX_W = LEN_W + 2,
  localparam int DEPTH = 4 << LEN_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              stat_i,
  input  logic [LEN_W-1:0]        len_f_i,
  input  logic [M_W-1:0]          m_f_i,
  input  logic [DEPTH*PORT_W-1:0] cal_tbl_i,
  input  logic [IDX_W:0]          act_ports_i,
  output logic                    st_valid_o,
  output logic [PORT_W-1:0]       st_port_o,
  output logic [1:0]              st_val_o,
  output logic                    cfg_err_o,
  input  logic                    rd_en_i,
  input  logic                    rd_sel_i,
  output logic [RD_W-1:0]         rd_data_o
);
  logic [1:0]       rst_ff;
  logic             rst_n_s;
  cal_phase_e       phase;
  logic [IDX_W-1:0] idx;
  logic             frame_miss;
  logic             dip_good, dip_bad;
  logic             sync_w;
  logic [CNT_W-1:0] cnt_w;
  logic             cnt_clr;
  logic [IDX_W:0]   cal_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_n_s = rst_ff[1];

  sts_cal_walker #(.LEN_W(LEN_W), .M_W(M_W)) u_walk (
    .clk(clk), .rst_n(rst_n_s), .stat_i(stat_i), .len_f_i(len_f_i),
    .m_f_i(m_f_i), .phase_o(phase), .idx_o(idx), .frame_miss_o(frame_miss)
  );

  sts_dip2_chk u_dip (
    .clk(clk), .rst_n(rst_n_s), .stat_i(stat_i), .phase_i(phase),
    .good_o(dip_good), .bad_o(dip_bad)
  );

  sts_sync_trk #(.LOCK_N(LOCK_N), .LOSE_N(LOSE_N)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .frame_miss_i(frame_miss),
    .good_i(dip_good), .bad_i(dip_bad), .sync_o(sync_w)
  );

  assign cnt_clr = rd_en_i && rd_sel_i;

  sts_err_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .inc_i(dip_bad), .clr_i(cnt_clr), .cnt_o(cnt_w)
  );

  assign st_valid_o = (phase == PH_CAL);
  assign st_port_o  = cal_tbl_i[idx*PORT_W +: PORT_W];
  assign st_val_o   = sync_w ? stat_i : W_IDLE;

  assign cal_len   = {1'b0, len_f_i, 2'b00} + (IDX_W+1)'(4);
  assign cfg_err_o = (cal_len < act_ports_i);

  always_comb begin
    rd_data_o = '0;
    if (rd_sel_i) rd_data_o[CNT_W-1:0] = cnt_w;
    else          rd_data_o[0]         = sync_w;
  end
endmodule

// File: rtl/sts_cal_rx_chk.sv
module sts_cal_rx_chk
  import sts_cal_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync,
  input logic [CNT_W-1:0] cnt,
  input logic             clr,
  input logic             good,
  input logic             bad,
  input logic             miss,
  input cal_phase_e       phase
);
  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt <= CNT_W'(1)));

  // R9
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt >= $past(cnt)));

  // R9
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == {CNT_W{1'b1}}) |=> (cnt == {CNT_W{1'b1}}));

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && !clr && cnt != {CNT_W{1'b1}}) |=> (cnt == $past(cnt) + 1'b1));

  // R5
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> $past(good));

  // R7
  miss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> (!sync && phase == PH_HUNT));

  // R3
  dip_then_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DIP) |=> (phase == PH_FRM));
endmodule

bind sts_cal_rx sts_cal_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .sync(sync_w), .cnt(cnt_w), .clr(cnt_clr),
  .good(dip_good), .bad(dip_bad), .miss(frame_miss), .phase(phase)
);

// File: tb/sts_cal_rx_test.sv
module sts_cal_rx_test;
  localparam int CLK_P  = 10;
  localparam int LEN_W  = 6;
  localparam int M_W    = 8;
  localparam int PORT_W = 8;
  localparam int CNT_W  = 4;
  localparam int RD_W   = 16;
  localparam int IDX_W  = LEN_W + 2;
  localparam int DEPTH  = 4 << LEN_W;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic                    clk, rst_n;
  logic [1:0]              stat;
  logic [LEN_W-1:0]        len_f;
  logic [M_W-1:0]          m_f;
  logic [DEPTH*PORT_W-1:0] tbl;
  logic [IDX_W:0]          act_ports;
  logic                    st_valid, cfg_err, rd_en, rd_sel;
  logic [PORT_W-1:0]       st_port;
  logic [1:0]              st_val;
  logic [RD_W-1:0]         rd_data;

  int n_chk, n_fail, last_rd;
  int sync_m, good_m, bad_m, err_m;
  bit done;

  sts_cal_rx #(.LEN_W(LEN_W), .M_W(M_W), .PORT_W(PORT_W), .CNT_W(CNT_W), .RD_W(RD_W)) uut (
    .clk(clk), .rst_n(rst_n), .stat_i(stat), .len_f_i(len_f), .m_f_i(m_f),
    .cal_tbl_i(tbl), .act_ports_i(act_ports), .st_valid_o(st_valid),
    .st_port_o(st_port), .st_val_o(st_val), .cfg_err_o(cfg_err),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_data_o(rd_data)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  function automatic int port_of(int i);
    return (i * 5 + 3) % 251;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic word(input logic [1:0] w, input bit exp_v, input int exp_port,
                      input int exp_val, input bit rd, input bit sel);
    @(negedge clk);
    stat = w; rd_en = rd; rd_sel = sel;
    #2;
    check("R1 R2 R3 strobe", int'(st_valid), int'(exp_v));
    if (exp_v) begin
      check("R2 port", int'(st_port), exp_port);
      check("R8 value", int'(st_val), exp_val);
    end
    last_rd = int'(rd_data);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; stat = 2'b00; rd_en = 1'b0; rd_sel = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    sync_m = 0; good_m = 0; bad_m = 0; err_m = 0;
    word(2'b00, 0, 0, 0, 1, 0);
    check("R5 reset lock", last_rd, 0);
    word(2'b00, 0, 0, 0, 1, 1);
    check("R9 reset count", last_rd, 0);
    word(2'b00, 0, 0, 0, 0, 0);
  endtask

  task automatic frame(input int lf, input int m, input bit bad, input bit rd_dip,
                       input bit miss, input bit rd_frm, input bit sel_frm,
                       input int seed, input string tag);
    logic [1:0] acc, w;
    int len;
    acc = 2'b00;
    len = 4 * (lf + 1);
    for (int rep = 0; rep <= m; rep++) begin
      for (int idx = 0; idx < len; idx++) begin
        w = 2'(rep * 7 + idx * 3 + seed);
        acc ^= w;
        word(w, 1, port_of(idx), (sync_m != 0) ? int'(w) : 2, 0, 0);
      end
    end
    word(acc ^ (bad ? 2'b01 : 2'b00), 0, 0, 0, rd_dip, 1);
    if (rd_dip) begin
      check("R10 read in error cycle", last_rd, err_m);
      err_m = 0;
    end
    if (bad) begin
      err_m = (err_m == CMAX) ? CMAX : err_m + 1;
      good_m = 0;
      if (sync_m != 0) begin
        bad_m++;
        if (bad_m == 4) begin sync_m = 0; bad_m = 0; end
      end
    end else begin
      bad_m = 0;
      if (sync_m == 0) begin
        good_m++;
        if (good_m == 4) begin sync_m = 1; good_m = 0; end
      end
    end
    word(miss ? 2'b00 : 2'b11, 0, 0, 0, rd_frm, sel_frm);
    if (rd_frm) begin
      if (sel_frm) begin
        check({tag, " R10 R11 count"}, last_rd, err_m);
        err_m = 0;
      end else begin
        check({tag, " R11 lock"}, last_rd, sync_m);
      end
    end
    if (miss) begin sync_m = 0; good_m = 0; bad_m = 0; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; stat = 2'b00; rd_en = 1'b0; rd_sel = 1'b0;
    for (int i = 0; i < DEPTH; i++) tbl[i*PORT_W +: PORT_W] = PORT_W'(port_of(i));
    act_ports = '0;
    act_ports[2] = 1'b1;

    // R2 R3 R4 R5 R8: sweep length and repetition fields
    for (int lf = 0; lf < 3; lf++) begin
      for (int m = 0; m < 3; m++) begin
        len_f = LEN_W'(lf); m_f = M_W'(m);
        do_reset();
        word(2'b11, 0, 0, 0, 0, 0);   // R1 alignment word
        for (int f = 0; f < 6; f++)
          frame(lf, m, 0, 0, 0, (f >= 3), (f == 5), f + lf + m, "R4 R5");
      end
    end

    // R6 R9: error runs while locked
    len_f = LEN_W'(1); m_f = M_W'(1);
    do_reset();
    word(2'b11, 0, 0, 0, 0, 0);
    for (int f = 0; f < 4; f++) frame(1, 1, 0, 0, 0, 0, 0, f, "R5");
    for (int f = 0; f < 3; f++) frame(1, 1, 1, 0, 0, 1, 0, f, "R6 kept");
    frame(1, 1, 0, 0, 0, 1, 0, 9, "R6 restart");
    for (int f = 0; f < 4; f++) frame(1, 1, 1, 0, 0, 1, 0, f, "R6 run");
    frame(1, 1, 0, 0, 0, 1, 1, 2, "R9 after runs");

    // R10: read and error in the same cycle
    frame(1, 1, 1, 1, 0, 0, 0, 3, "R10");
    frame(1, 1, 0, 0, 0, 1, 1, 4, "R10 collision");

    // R9: saturation
    for (int f = 0; f < CMAX + 5; f++) frame(1, 1, 1, 0, 0, 0, 0, f, "R9");
    frame(1, 1, 0, 0, 0, 1, 1, 5, "R9 saturate");
    frame(1, 1, 0, 0, 0, 1, 1, 6, "R10 cleared");

    // R7: missing framing word
    for (int f = 0; f < 4; f++) frame(1, 1, 0, 0, 0, 1, 0, f, "R7 relock");
    frame(1, 1, 0, 0, 1, 1, 0, 7, "R7 before miss");
    for (int k = 0; k < 3; k++) word(2'b00, 0, 0, 0, 0, 0);   // R7 R1 searching
    word(2'b01, 0, 0, 0, 0, 0);
    word(2'b11, 0, 0, 0, 0, 0);
    frame(1, 1, 0, 0, 0, 1, 0, 8, "R7 after miss");

    // R12: configuration check
    @(negedge clk);
    len_f = LEN_W'(1); act_ports = (IDX_W+1)'(8);
    #1 check("R12 equal", int'(cfg_err), 0);
    act_ports = (IDX_W+1)'(9);
    #1 check("R12 over", int'(cfg_err), 1);
    len_f = LEN_W'(0); act_ports = (IDX_W+1)'(4);
    #1 check("R12 min equal", int'(cfg_err), 0);
    act_ports = (IDX_W+1)'(5);
    #1 check("R12 min over", int'(cfg_err), 1);
    len_f = LEN_W'(63); act_ports = (IDX_W+1)'(256);
    #1 check("R12 max", int'(cfg_err), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule